// File: doc/BRIEF.md
# Boot Authentication Reset Sequencer

This block gates a system's reset at power-up. While power is good it keeps the system reset line asserted and listens on a serial bit link for a cartridge security chip. The chip sends three 4-bit values in a fixed order: region code, then encrypted seed, then checksum. Each value is compared against a configured expected value. If all three match, the block issues one write of the seed to a fixed memory address. It then releases system reset.

Once the system is running, the block keeps receiving nibbles from the ongoing security exchange. It compares each one against a supplied expected value, because the cipher that produces these values is modelled only as a comparator. Any mismatch forces reset again. A silent link counts as a mismatch once a configurable per-nibble timeout runs out. A failure latches until power-good drops, which returns the block to waiting.

Top module: `boot_auth_seq`

## Requirements
- R1: After the synchronous reset `rst`, `sys_rst` is 1, `wr_en` is 0 and `status` reads waiting (2'b00).
- R2: In waiting with `pwr_good` high, the next clock edge moves to authenticating (`status` 2'b01). `sys_rst` stays 1 in every state except running (2'b10).
- R3: A link bit is taken only on a rising edge where `link_valid` is 1. Four taken bits form one nibble, the first taken bit being the nibble's MSB (bit 3). Edges with `link_valid` 0 change nothing.
- R4: During authentication the first nibble is compared with `exp_region`, the second with `exp_seed` and the third with `exp_check`. When all three match, the block spends exactly one cycle with `wr_en` 1, `wr_addr` equal to 32'hBFC007E4, `wr_data` equal to the received seed zero-extended, and `sys_rst` still 1. In the cycle after that, `sys_rst` is 0 and `status` is running.
- R5: A nibble that differs from its expected value during authentication moves the block to failed (2'b11) on the edge after the nibble completes. No write occurs and `sys_rst` stays 1.
- R6: If TIMEOUT_CYC consecutive clock edges pass in authenticating or running without a nibble completing, the block moves to failed.
- R7: In running, a received nibble equal to `exp_run` keeps the block running. A differing one moves it to failed, with `sys_rst` 1 again.
- R8: Failed holds while `pwr_good` stays high. Link activity is ignored there, and matching nibbles do not leave failed.
- R9: `pwr_good` low at a clock edge puts the block in waiting with `sys_rst` 1, from any state. A partly received nibble is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply good; low forces waiting |
| link_bit | input | 1 | Serial data bit from the security chip |
| link_valid | input | 1 | Qualifies link_bit on this edge |
| exp_region | input | 4 | Expected region nibble |
| exp_seed | input | 4 | Expected seed nibble |
| exp_check | input | 4 | Expected checksum nibble |
| exp_run | input | 4 | Expected value of the next exchange nibble while running |
| sys_rst | output | 1 | System reset, active high |
| wr_en | output | 1 | Seed write strobe |
| wr_addr | output | 32 | Seed write address |
| wr_data | output | 32 | Seed write data (zero-extended seed) |
| status | output | 2 | 00 waiting, 01 authenticating, 10 running, 11 failed |

## Verification
The assertions check several rules on every cycle: every release of reset comes right after a seed write cycle, the write address is always the fixed seed location, failed is sticky, power-good loss forces waiting, and the silence counter never passes its limit. The bench scenarios are needed for what depends on data values: MSB-first assembly, the region/seed/checksum order of comparison, the exact cycle of release, the exact length of the timeout, and discarding of a partial nibble after a power drop.

// File: rtl/boot_auth_pkg.sv
package boot_auth_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        STAT_WAITING = 2'b00,
        STAT_AUTHING = 2'b01,
        STAT_RUNNING = 2'b10,
        STAT_FAILED  = 2'b11
    } stat_e;

    typedef enum logic [2:0] {
        FSM_WAIT,
        FSM_AUTH,
        FSM_SEED,
        FSM_RUN,
        FSM_FAIL
    } fsm_e;

    typedef struct packed {
        logic             done;
        logic [NIB_W-1:0] value;
    } nibble_t;

    function automatic stat_e to_status(fsm_e s);
        case (s)
            FSM_WAIT: return STAT_WAITING;
            FSM_AUTH,
            FSM_SEED: return STAT_AUTHING;
            FSM_RUN:  return STAT_RUNNING;
            default:  return STAT_FAILED;
        endcase
    endfunction

endpackage

// File: rtl/bas_nibble_rx.sv
module bas_nibble_rx
    import boot_auth_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    bit_in,
    input  logic    bit_valid,
    output nibble_t nib
);
    localparam int CNT_W = $clog2(NIB_W);

    logic [NIB_W-1:0] shreg;
    logic [CNT_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg     <= '0;
            bcnt      <= '0;
            nib.done  <= 1'b0;
            nib.value <= '0;
        end else begin
            nib.done <= 1'b0;
            if (bit_valid) begin
                if (bcnt == CNT_W'(NIB_W - 1)) begin
                    nib.value <= {shreg[NIB_W-2:0], bit_in};
                    nib.done  <= 1'b1;
                    bcnt      <= '0;
                    shreg     <= '0;
                end else begin
                    shreg <= {shreg[NIB_W-2:0], bit_in};
                    bcnt  <= bcnt + 1'b1;
                end
            end
        end
    end

    // R3: a nibble completes only on an edge that took a bit
    p_done_needs_bit_r3: assert property (@(posedge clk) disable iff (rst)
        nib.done |-> $past(bit_valid));

endmodule

// File: rtl/bas_timeout.sv
module bas_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick)
            cnt <= '0;
        else if (cnt != CW'(LIMIT - 1))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && !kick && (cnt == CW'(LIMIT - 1));

    // R6: the silence counter never passes its limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/boot_auth_seq.sv
module boot_auth_seq
    import boot_auth_pkg::*;
#(
    parameter int          TIMEOUT_CYC = 64,
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter logic [31:0] SEED_ADDR   = 32'hBFC0_07E4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              link_bit,
    input  logic              link_valid,
    input  logic [3:0]        exp_region,
    input  logic [3:0]        exp_seed,
    input  logic [3:0]        exp_check,
    input  logic [3:0]        exp_run,
    output logic              sys_rst,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        status
);
    localparam int LAST_IDX = 2;

    fsm_e             state, state_nx;
    nibble_t          nib;
    logic [1:0]       idx;
    logic [NIB_W-1:0] seed_q;
    logic [NIB_W-1:0] want;
    logic             expired;
    logic             rx_clr;
    logic             tmo_run;

    assign rx_clr  = (state == FSM_WAIT) || (state == FSM_FAIL);
    assign tmo_run = (state == FSM_AUTH) || (state == FSM_RUN);

    bas_nibble_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clr),
        .bit_in    (link_bit),
        .bit_valid (link_valid),
        .nib       (nib)
    );

    bas_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (tmo_run),
        .kick    (nib.done),
        .expired (expired)
    );

    always_comb begin
        case (idx)
            2'd0:    want = exp_region;
            2'd1:    want = exp_seed;
            default: want = exp_check;
        endcase
    end

    always_comb begin
        state_nx = state;
        if (!pwr_good) begin
            state_nx = FSM_WAIT;
        end else begin
            case (state)
                FSM_WAIT: state_nx = FSM_AUTH;
                FSM_AUTH: begin
                    if (expired)
                        state_nx = FSM_FAIL;
                    else if (nib.done) begin
                        if (nib.value != want)
                            state_nx = FSM_FAIL;
                        else if (idx == 2'(LAST_IDX))
                            state_nx = FSM_SEED;
                    end
                end
                FSM_SEED: state_nx = FSM_RUN;
                FSM_RUN: begin
                    if (expired || (nib.done && nib.value != exp_run))
                        state_nx = FSM_FAIL;
                end
                default: state_nx = FSM_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FSM_WAIT;
            idx    <= '0;
            seed_q <= '0;
        end else begin
            state <= state_nx;
            if (state != FSM_AUTH)
                idx <= '0;
            else if (nib.done)
                idx <= idx + 1'b1;
            if (state == FSM_AUTH && nib.done && idx == 2'd1)
                seed_q <= nib.value;
        end
    end

    assign sys_rst = (state != FSM_RUN);
    assign wr_en   = (state == FSM_SEED);
    assign wr_addr = ADDR_W'(SEED_ADDR);
    assign wr_data = DATA_W'(seed_q);
    assign status  = to_status(state);

    // R4: release of reset is always preceded by the seed write cycle
    p_release_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> $past(wr_en));
    // R4: the write targets the fixed seed address while reset is held
    p_write_addr_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == ADDR_W'(SEED_ADDR)) && sys_rst);
    // R8: failed is sticky while power stays good
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status == STAT_FAILED) && pwr_good |=> status == STAT_FAILED);
    // R9: power loss forces waiting with reset held
    p_pwr_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (status == STAT_WAITING) && sys_rst);
    // R2: reset is only released while running
    p_rst_held_r2: assert property (@(posedge clk) disable iff (rst)
        (status != STAT_RUNNING) |-> sys_rst);

endmodule

// File: tb/boot_auth_seq_tb.sv
module boot_auth_seq_tb;
    localparam int TO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good = 1'b0;
    logic        link_bit = 1'b0;
    logic        link_valid = 1'b0;
    logic [3:0]  exp_region = '0, exp_seed = '0, exp_check = '0, exp_run = '0;
    logic        sys_rst, wr_en;
    logic [31:0] wr_addr, wr_data;
    logic [1:0]  status;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;

    localparam logic [1:0] S_WAIT = 2'b00, S_AUTH = 2'b01, S_RUN = 2'b10, S_FAIL = 2'b11;

    always #5 clk = ~clk;

    boot_auth_seq #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good),
        .link_bit(link_bit), .link_valid(link_valid),
        .exp_region(exp_region), .exp_seed(exp_seed),
        .exp_check(exp_check), .exp_run(exp_run),
        .sys_rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .status(status)
    );

    always @(negedge clk) if (wr_en) wr_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // idle cycles drive random noise on link_bit with valid low (R3)
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            link_valid = 1'b0;
            link_bit   = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic send_nib(input logic [3:0] v);
        for (int i = 3; i >= 0; i--) begin
            link_valid = 1'b1;
            link_bit   = v[i];
            @(negedge clk);
        end
        link_valid = 1'b0;
    endtask

    function automatic logic [3:0] corrupt(input logic [3:0] v);
        return v ^ 4'(1 + ($urandom % 15));
    endfunction

    task automatic power_cycle();
        pwr_good = 1'b0;
        tick(1);
        chk("R9 waiting after power drop", {30'd0, status}, {30'd0, S_WAIT});
        chk("R9 reset held after power drop", {31'd0, sys_rst}, 32'd1);
        pwr_good = 1'b1;
        tick(1);
        chk("R2 authenticating", {30'd0, status}, {30'd0, S_AUTH});
    endtask

    // full good authentication, ends in running
    task automatic good_auth(input string tag);
        int w0;
        w0 = wr_cnt;
        send_nib(exp_region); tick(1);
        chk({tag, " R4 after region"}, {30'd0, status}, {30'd0, S_AUTH});
        send_nib(exp_seed); tick(1);
        send_nib(exp_check); tick(1);
        chk({tag, " R4 write strobe"}, {31'd0, wr_en}, 32'd1);
        chk({tag, " R4 write addr"}, wr_addr, 32'hBFC007E4);
        chk({tag, " R4 write data"}, wr_data, {28'd0, exp_seed});
        chk({tag, " R4 reset held during write"}, {31'd0, sys_rst}, 32'd1);
        tick(1);
        chk({tag, " R4 released"}, {31'd0, sys_rst}, 32'd0);
        chk({tag, " R4 running"}, {30'd0, status}, {30'd0, S_RUN});
        chk({tag, " R4 single write"}, 32'(wr_cnt - w0), 32'd1);
    endtask

    task automatic rand_cfg();
        exp_region = 4'($urandom);
        exp_seed   = 4'($urandom);
        exp_check  = 4'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset sys_rst", {31'd0, sys_rst}, 32'd1);
        chk("R1 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R1 reset status", {30'd0, status}, {30'd0, S_WAIT});
        pwr_good = 1'b1;
        tick(1);
        chk("R2 to authenticating", {30'd0, status}, {30'd0, S_AUTH});
        chk("R2 reset held", {31'd0, sys_rst}, 32'd1);

        // R3 MSB first: asymmetric nibbles reveal bit order
        exp_region = 4'b1000; exp_seed = 4'b0011; exp_check = 4'b1101;
        good_auth("directed");

        // R6 timeout in running
        tick(TO - 1);
        chk("R6 running before limit", {30'd0, status}, {30'd0, S_RUN});
        tick(1);
        chk("R6 running timeout", {30'd0, status}, {30'd0, S_FAIL});
        chk("R6 reset reasserted", {31'd0, sys_rst}, 32'd1);

        // R8 failed is sticky, matching nibbles ignored
        exp_run = 4'h5;
        send_nib(4'h5); send_nib(4'h5); tick(2);
        chk("R8 stays failed", {30'd0, status}, {30'd0, S_FAIL});

        // R6 timeout in authentication
        power_cycle();
        tick(TO - 1);
        chk("R6 auth before limit", {30'd0, status}, {30'd0, S_AUTH});
        tick(1);
        chk("R6 auth timeout", {30'd0, status}, {30'd0, S_FAIL});

        // R9 partial nibble discarded
        power_cycle();
        rand_cfg();
        link_valid = 1'b1; link_bit = 1'b1; @(negedge clk);
        link_bit = 1'b0; @(negedge clk);
        link_valid = 1'b0;
        power_cycle();
        good_auth("R9 partial discarded");

        // random scenarios
        for (int it = 0; it < 40; it++) begin
            int bad_pos;
            int w0;
            logic [3:0] vals [3];
            power_cycle();
            rand_cfg();
            bad_pos = int'($urandom % 4);
            if (bad_pos == 3) begin
                good_auth("random");
                for (int k = 0; k < 6; k++) begin
                    logic mism;
                    exp_run = 4'($urandom);
                    mism = (k == 5) && 1'($urandom);
                    send_nib(mism ? corrupt(exp_run) : exp_run);
                    tick(int'($urandom % 3) + 1);
                    chk(mism ? "R7 run mismatch" : "R7 run match", {30'd0, status},
                        {30'd0, mism ? S_FAIL : S_RUN});
                    chk("R7 sys_rst", {31'd0, sys_rst}, {31'd0, mism});
                end
            end else begin
                vals[0] = exp_region; vals[1] = exp_seed; vals[2] = exp_check;
                w0 = wr_cnt;
                for (int k = 0; k <= bad_pos; k++) begin
                    send_nib(k == bad_pos ? corrupt(vals[k]) : vals[k]);
                    tick(1);
                end
                chk("R5 auth mismatch fails", {30'd0, status}, {30'd0, S_FAIL});
                tick(3);
                chk("R5 no write", 32'(wr_cnt - w0), 32'd0);
                chk("R5 reset held", {31'd0, sys_rst}, 32'd1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule